// File: doc/BRIEF.md
# Four-Bit Calculator with Decimal Digit Result

This block is a purely combinational calculator. Two 4-bit operands and a 2-bit operation code go in. Out comes a three-digit binary-coded-decimal magnitude, a sign flag, and the carry and overflow flags of the internal adder/subtractor. The block holds an add/subtract unit, an array multiplier, a result selector, a sign-to-magnitude stage and a shift-and-adjust binary-to-decimal converter. It is meant to feed a decimal display or any consumer that wants decimal digits.

Addition and multiplication treat the operands as unsigned numbers. Subtraction computes the operand difference. A negative difference is two's-complemented and shown as a positive magnitude with the sign flag raised. The flags of the adder/subtractor are also visible to the caller.

Top module: `calc_bcd`

## Requirements
- R1: With op_code 00, bcd_out holds the decimal digits of opnd_a + opnd_b as unsigned numbers (0 to 30), and is_neg is 0.
- R2: With op_code 01 and opnd_a >= opnd_b, bcd_out holds the digits of opnd_a - opnd_b, and is_neg is 0.
- R3: With op_code 01 and opnd_a < opnd_b, bcd_out holds the digits of opnd_b - opnd_a (1 to 15), and is_neg is 1. is_neg is never 1 for any other op_code.
- R4: With op_code 10 or 11, bcd_out holds the digits of opnd_a * opnd_b as unsigned numbers (0 to 225), and is_neg is 0.
- R5: For addition, add_carry is 1 exactly when opnd_a + opnd_b exceeds 15. For subtraction, add_carry is the carry out of opnd_a + ~opnd_b + 1, which is 1 exactly when opnd_a >= opnd_b.
- R6: For addition and subtraction, add_ovf is 1 exactly when the two's-complement 4-bit result overflows. In that case the signed sum or difference lies outside -8 to 7.
- R7: With op_code 10 or 11, add_carry and add_ovf are both 0.
- R8: bcd_out[11:8] holds the hundreds digit, bcd_out[7:4] the tens digit and bcd_out[3:0] the ones digit. Each digit is in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 4 | First operand |
| opnd_b | input | 4 | Second operand |
| op_code | input | 2 | 00 add, 01 subtract, 1x multiply |
| bcd_out | output | 12 | Three decimal digits of the result magnitude |
| is_neg | output | 1 | Result of a subtraction is negative |
| add_carry | output | 1 | Carry out of the adder/subtractor (0 when multiplying) |
| add_ovf | output | 1 | Signed overflow of the adder/subtractor (0 when multiplying) |

## Verification
Every output of this block is combinational, so each result is due in the same cycle its operands and operation code are applied. There is no register anywhere on the path. The bench changes the inputs just after a rising edge and samples all four outputs at the following falling edge, half a period later, when the logic has settled. Each of the 1024 combinations of operands and operation code is compared against an integer model in that same cycle.

// File: rtl/calc_bcd_pkg.sv
`timescale 1ns/1ps
package calc_bcd_pkg;

  typedef enum logic [1:0] {
    OP_ADD     = 2'b00,
    OP_SUB     = 2'b01,
    OP_MUL     = 2'b10,
    OP_MUL_ALT = 2'b11
  } op_e;

  // Number of decimal digits needed to hold the largest value of 'bits' bits
  function automatic int digits_for(input int bits);
    longint maxv;
    int     n;
    maxv = (longint'(1) << bits) - 1;
    n    = 1;
    while (maxv >= 10) begin
      maxv = maxv / 10;
      n    = n + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/addsub_unit.sv
`timescale 1ns/1ps
module addsub_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W-1:0] low;     // lower bits plus carry into the MSB
  logic [1:0]   top;
  logic         c_msb;

  assign b_eff = b ^ {W{sub}};
  assign low   = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, sub};
  assign c_msb = low[W-1];
  assign top   = {1'b0, a[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, c_msb};
  assign sum   = {top[0], low[W-2:0]};
  assign cout  = top[1];
  assign ovf   = top[1] ^ c_msb;

  always_comb begin
    if (!$isunknown({a, b, sub}) && !sub) begin
      // R6
      add_ovf_sign_chk: assert (!ovf || ((a[W-1] == b[W-1]) && (sum[W-1] != a[W-1])));
    end
  end
endmodule

// File: rtl/mult_array.sv
`timescale 1ns/1ps
module mult_array #(
  parameter int W = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  logic [W:0][PW-1:0] acc;

  assign acc[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [PW-1:0] pp;
    assign pp         = {{W{1'b0}}, a & {W{b[i]}}} << i;
    assign acc[i+1]   = acc[i] + pp;
  end

  assign p = acc[W];
endmodule

// File: rtl/dabble_cell.sv
`timescale 1ns/1ps
module dabble_cell (
  input  logic [3:0] din,
  output logic [3:0] dout
);
  assign dout = (din >= 4'd5) ? din + 4'd3 : din;

  always_comb begin
    if (!$isunknown(din)) begin
      // R8
      cell_digit_chk: assert (din <= 4'd9);
    end
  end
endmodule

// File: rtl/dabble_conv.sv
`timescale 1ns/1ps
module dabble_conv #(
  parameter int BIN_W  = 8,
  parameter int DIGITS = 3
) (
  input  logic [BIN_W-1:0]    bin,
  output logic [4*DIGITS-1:0] bcd
);
  localparam int BCD_W = 4 * DIGITS;

  logic [BIN_W:0][BCD_W-1:0] stage;

  assign stage[0] = '0;

  for (genvar s = 0; s < BIN_W; s++) begin : g_step
    logic [BCD_W-1:0] adj;
    for (genvar d = 0; d < DIGITS; d++) begin : g_dig
      dabble_cell u_cell (
        .din  (stage[s][4*d +: 4]),
        .dout (adj[4*d +: 4])
      );
    end
    assign stage[s+1] = {adj[BCD_W-2:0], bin[BIN_W-1-s]};

    always_comb begin
      if (!$isunknown(bin)) begin
        // R8
        top_bit_lost_chk: assert (!adj[BCD_W-1]);
      end
    end
  end

  assign bcd = stage[BIN_W];

  for (genvar d = 0; d < DIGITS; d++) begin : g_outchk
    always_comb begin
      if (!$isunknown(bin)) begin
        // R8
        out_digit_chk: assert (bcd[4*d +: 4] <= 4'd9);
      end
    end
  end
endmodule

// File: rtl/calc_bcd.sv
`timescale 1ns/1ps
module calc_bcd
  import calc_bcd_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic [OPW-1:0]                       opnd_a,
  input  logic [OPW-1:0]                       opnd_b,
  input  logic [1:0]                           op_code,
  output logic [4*digits_for(2*OPW)-1:0]       bcd_out,
  output logic                                 is_neg,
  output logic                                 add_carry,
  output logic                                 add_ovf
);
  localparam int PW     = 2 * OPW;
  localparam int DIGITS = digits_for(PW);

  op_e            op;
  logic           is_sub;
  logic           is_mul;
  logic [OPW-1:0] sum;
  logic [OPW-1:0] sum_neg;
  logic           cout;
  logic           ovf;
  logic [PW-1:0]  prod;
  logic [PW-1:0]  mag;
  logic           neg_c;

  assign op     = op_e'(op_code);
  assign is_sub = (op == OP_SUB);
  assign is_mul = (op == OP_MUL) || (op == OP_MUL_ALT);

  addsub_unit #(.W(OPW)) u_addsub (
    .a    (opnd_a),
    .b    (opnd_b),
    .sub  (is_sub),
    .sum  (sum),
    .cout (cout),
    .ovf  (ovf)
  );

  mult_array #(.W(OPW)) u_mult (
    .a (opnd_a),
    .b (opnd_b),
    .p (prod)
  );

  assign sum_neg = ~sum + {{(OPW-1){1'b0}}, 1'b1};

  // Result selection and sign-magnitude conversion
  always_comb begin
    mag   = '0;
    neg_c = 1'b0;
    if (is_mul) begin
      mag = prod;
    end else if (is_sub) begin
      if (cout) begin
        mag = PW'(sum);
      end else begin
        neg_c = 1'b1;
        mag   = PW'(sum_neg);
      end
    end else begin
      mag = PW'({cout, sum});
    end
  end

  dabble_conv #(.BIN_W(PW), .DIGITS(DIGITS)) u_conv (
    .bin (mag),
    .bcd (bcd_out)
  );

  assign is_neg    = neg_c;
  assign add_carry = is_mul ? 1'b0 : cout;
  assign add_ovf   = is_mul ? 1'b0 : ovf;

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, op_code})) begin
      // R3
      neg_only_sub_chk: assert (!is_neg || (op_code == 2'b01));
      // R3
      neg_when_less_chk: assert (!is_neg || (opnd_a < opnd_b));
      // R7
      mul_flags_chk: assert (!op_code[1] || (!add_carry && !add_ovf));
    end
  end
endmodule

// File: tb/calc_bcd_test.sv
`timescale 1ns/1ps
module calc_bcd_test;
  logic        clk;
  logic        rst_n;
  logic [3:0]  opnd_a;
  logic [3:0]  opnd_b;
  logic [1:0]  op_code;
  logic [11:0] bcd_out;
  logic        is_neg;
  logic        add_carry;
  logic        add_ovf;

  int checks;
  int errors;
  bit done;

  calc_bcd uut (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_code   (op_code),
    .bcd_out   (bcd_out),
    .is_neg    (is_neg),
    .add_carry (add_carry),
    .add_ovf   (add_ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int to_bcd(input int v);
    return ((v / 100) % 10) * 256 + ((v / 10) % 10) * 16 + (v % 10);
  endfunction

  function automatic int sx4(input int v);
    return (v > 7) ? v - 16 : v;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (a=%0d b=%0d op=%0d)",
               tag, what, act, exp, opnd_a, opnd_b, op_code);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    opnd_a = '0;
    opnd_b = '0;
    op_code = 2'b00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // Reset state: zero operands, add -> all zero (R1)
    check("R1", "reset bcd", int'(bcd_out), 0);
    check("R1", "reset neg", int'(is_neg), 0);

    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int    val;
          int    neg;
          int    cy;
          int    ov;
          string tag;
          string ftag;
          @(posedge clk);
          #1;
          opnd_a  = 4'(a);
          opnd_b  = 4'(b);
          op_code = 2'(op);
          if (op == 0) begin
            val = a + b; neg = 0; tag = "R1";
            cy  = (a + b > 15) ? 1 : 0;
            ov  = ((sx4(a) + sx4(b) > 7) || (sx4(a) + sx4(b) < -8)) ? 1 : 0;
          end else if (op == 1) begin
            if (a >= b) begin val = a - b; neg = 0; tag = "R2"; end
            else        begin val = b - a; neg = 1; tag = "R3"; end
            cy  = (a >= b) ? 1 : 0;
            ov  = ((sx4(a) - sx4(b) > 7) || (sx4(a) - sx4(b) < -8)) ? 1 : 0;
          end else begin
            val = a * b; neg = 0; tag = "R4";
            cy  = 0; ov = 0;
          end
          ftag = (op >= 2) ? "R7" : "R5";
          @(negedge clk);
          check(tag, "bcd", int'(bcd_out), to_bcd(val));
          check(tag, "neg", int'(is_neg), neg);
          check(ftag, "carry", int'(add_carry), cy);
          check((op >= 2) ? "R7" : "R6", "ovf", int'(add_ovf), ov);
          // R8: each digit of the result stays within 0..9
          check("R8", "digits", int'((bcd_out[11:8] <= 9) && (bcd_out[7:4] <= 9)
                                     && (bcd_out[3:0] <= 9)), 1);
        end
      end
    end
    finish_run();
  end
endmodule